// File: doc/BRIEF.md
# SDRAM Power-Up and Mode-Set Sequencer

This block takes a synchronous DRAM from power-on to a usable state. After reset is released it counts out a stabilisation period, holding off any mode-set request until that period is over. Once the period ends it programs the memory's mode register and paces a run of initial auto-refresh cycles.

Software programs the mode register with one ordinary CPU write. The write is a word-size store into a fixed address window, and the memory value is the address offset inside that window; the write data plays no part. The block expands each such write into two memory commands: a precharge of every bank, then a mode register load whose address bus carries the offset unchanged. A control bit can add one idle cycle between the two commands.

Alongside this, a refresh pacer issues a configurable number of dummy auto-refreshes at a short interval. It then raises a done flag and falls back to the normal refresh interval. The CPU side is a valid/ready port. A write is taken on a clock edge where both `cpu_valid` and `cpu_ready` are high. While `cpu_ready` is low the CPU must hold `cpu_valid`, `cpu_addr` and `cpu_size` steady, so a stalled write is never lost.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and after it is released, the command pins show NOP ({cs_n,ras_n,cas_n,we_n} = 0111), `sd_addr` is 0, and `cpu_ready`, `init_done` and `mode_err` are 0.
- R2: `cpu_ready` stays low until PWR_CYCLES rising edges have passed since reset release. A write held during that time is accepted afterwards and not dropped.
- R3: A write is good when `cpu_size` is word (2'b01) and `cpu_addr[31:12]` equals 20'hFFFF8. A good write accepted at edge k shows the all-bank precharge (0010, with `sd_addr` bit 10 set) in the cycle after k. The mode load (0000) follows in the next cycle when `ctl_trp_gap` is 0.
- R4: When `ctl_trp_gap` is 1 in the precharge cycle, one NOP cycle comes between the precharge and the mode load.
- R5: During the mode-load cycle, `sd_addr` equals `cpu_addr[11:0]` of the accepted write. For example, offset 0x446 or 0x8C8 reaches the memory unchanged.
- R6: A write that is not good is still accepted. It puts no command on the pins (NOP persists) and sets `mode_err`, which stays high until reset.
- R7: Once the wait is over, refresh commands (0001) are issued. The first N_DUMMY of them are spaced SHORT_IVL+1 cycles apart when nothing else is running.
- R8: `init_done` rises in the cycle of the N_DUMMY-th refresh and stays high. Later refreshes are spaced NORMAL_IVL+1 cycles apart when nothing else is running.
- R9: While a refresh is pending, `cpu_ready` is low and the refresh is issued before any waiting write.
- R10: `cpu_ready` is low from the edge that accepts a good write until the mode-load cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | 1 | CPU write request |
| cpu_ready | output | 1 | Write accepted on this edge if valid |
| cpu_addr | input | 32 | Write address; the offset carries the mode value |
| cpu_size | input | 2 | Access size: 00 byte, 01 word, 10 long |
| ctl_trp_gap | input | 1 | Insert idle cycle between precharge and mode load |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Memory address bus |
| init_done | output | 1 | Dummy refresh run complete |
| mode_err | output | 1 | Sticky: a rejected mode-set write was seen |

## Verification
The hardest case to reach is a mode-set write that meets a pending refresh. The write is stalled, and the refresh goes out first.

The stimulus places a write just as the power-up wait ends, and more writes during the short dummy-refresh interval. Refresh timing then drifts into the write traffic. The bench model tracks each cycle exactly, so any error in priority or stall handling shows up as a mismatch on the ready line or the command pins.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;
  // command encoding on {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b0111,
    CMD_PALL = 4'b0010,
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001
  } sd_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TP,
    ST_GAP,
    ST_TMW,
    ST_REF
  } seq_state_e;

  localparam logic [1:0] SZ_WORD = 2'b01;
endpackage

// File: rtl/sdinit_pwr_timer.sv
module sdinit_pwr_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  output logic pwr_ok
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
  end

  assign pwr_ok = (cnt_q == LIMIT);

  // R2
  pwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_ok |=> pwr_ok);
endmodule

// File: rtl/sdinit_ref_pacer.sv
module sdinit_ref_pacer #(
  parameter int N_DUMMY    = 8,
  parameter int SHORT_IVL  = 16,
  parameter int NORMAL_IVL = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic req,
  output logic init_done
);
  localparam int TW = $clog2(NORMAL_IVL + 1);
  localparam int DW = $clog2(N_DUMMY + 1);
  localparam logic [TW-1:0] SHORT_M1  = TW'(SHORT_IVL - 1);
  localparam logic [TW-1:0] NORMAL_M1 = TW'(NORMAL_IVL - 1);
  localparam logic [DW-1:0] DUMMY_LIM = DW'(N_DUMMY);

  logic [TW-1:0] tick_q;
  logic [DW-1:0] dummy_q;
  logic          req_q;
  logic [TW-1:0] ivl_m1;

  assign init_done = (dummy_q == DUMMY_LIM);
  assign ivl_m1    = init_done ? NORMAL_M1 : SHORT_M1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      req_q  <= 1'b0;
    end else if (ack) begin
      req_q <= 1'b0;
    end else if (enable && !req_q) begin
      if (tick_q == ivl_m1) begin
        req_q  <= 1'b1;
        tick_q <= '0;
      end else begin
        tick_q <= tick_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dummy_q <= '0;
    else if (ack && !init_done) dummy_q <= dummy_q + 1'b1;
  end

  assign req = req_q;

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> req);
  // R7
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> req);
  // R8
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);
endmodule

// File: rtl/sdinit_cmd_seq.sv
module sdinit_cmd_seq
  import sdinit_pkg::*;
#(
  parameter logic [31:0] BASE      = 32'hFFFF_8000,
  parameter int          MODE_BITS = 12,
  parameter int          AP_BIT    = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pwr_ok,
  input  logic                 ref_req,
  input  logic                 cpu_valid,
  input  logic [31:0]          cpu_addr,
  input  logic [1:0]           cpu_size,
  input  logic                 trp_gap,
  output logic                 cpu_ready,
  output logic                 ref_ack,
  output sd_cmd_e              cmd,
  output logic [MODE_BITS-1:0] addr,
  output logic                 err
);
  localparam logic [MODE_BITS-1:0] AP_MASK = MODE_BITS'(1) << AP_BIT;

  seq_state_e           state_q, state_d;
  sd_cmd_e              cmd_q, cmd_d;
  logic [MODE_BITS-1:0] addr_q, addr_d;
  logic [MODE_BITS-1:0] mode_q;
  logic                 err_q;
  logic                 in_window, good, accept, idle;

  assign in_window = (cpu_addr[31:MODE_BITS] == BASE[31:MODE_BITS]);
  assign good      = in_window && (cpu_size == SZ_WORD);
  assign idle      = (state_q == ST_IDLE);
  assign cpu_ready = idle && pwr_ok && !ref_req;
  assign ref_ack   = idle && ref_req;
  assign accept    = cpu_valid && cpu_ready;

  always_comb begin
    state_d = state_q;
    cmd_d   = CMD_NOP;
    addr_d  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (ref_ack) begin
          state_d = ST_REF;
          cmd_d   = CMD_REF;
        end else if (accept && good) begin
          state_d = ST_TP;
          cmd_d   = CMD_PALL;
          addr_d  = AP_MASK;
        end
      end
      ST_TP: begin
        if (trp_gap) begin
          state_d = ST_GAP;
        end else begin
          state_d = ST_TMW;
          cmd_d   = CMD_MRS;
          addr_d  = mode_q;
        end
      end
      ST_GAP: begin
        state_d = ST_TMW;
        cmd_d   = CMD_MRS;
        addr_d  = mode_q;
      end
      ST_TMW:  state_d = ST_IDLE;
      ST_REF:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else if (accept && good) mode_q <= cpu_addr[MODE_BITS-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else if (accept && !good) err_q <= 1'b1;
  end

  assign cmd  = cmd_q;
  assign addr = addr_q;
  assign err  = err_q;

  // R3
  pall_to_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PALL && !trp_gap) |=> (cmd_q == CMD_MRS));
  // R4
  pall_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_q == CMD_PALL && trp_gap) |=> (cmd_q == CMD_NOP));
  // R6
  bad_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !good) |=> (err_q && cmd_q == CMD_NOP));
  // R2
  ready_after_pwr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> pwr_ok);
  // R9
  ref_blocks_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_req |-> !cpu_ready);
  // R10
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && good) |=> !cpu_ready);
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int          PWR_CYCLES = 5000,
  parameter int          N_DUMMY    = 8,
  parameter int          SHORT_IVL  = 16,
  parameter int          NORMAL_IVL = 780,
  parameter logic [31:0] MODE_BASE  = 32'hFFFF_8000,
  parameter int          MODE_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_valid,
  output logic                 cpu_ready,
  input  logic [31:0]          cpu_addr,
  input  logic [1:0]           cpu_size,
  input  logic                 ctl_trp_gap,
  output logic                 sd_cs_n,
  output logic                 sd_ras_n,
  output logic                 sd_cas_n,
  output logic                 sd_we_n,
  output logic [MODE_BITS-1:0] sd_addr,
  output logic                 init_done,
  output logic                 mode_err
);
  logic    pwr_ok, ref_req, ref_ack;
  sd_cmd_e cmd;

  sdinit_pwr_timer #(.CYCLES(PWR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok)
  );

  sdinit_ref_pacer #(
    .N_DUMMY(N_DUMMY), .SHORT_IVL(SHORT_IVL), .NORMAL_IVL(NORMAL_IVL)
  ) u_pacer (
    .clk(clk), .rst_n(rst_n), .enable(pwr_ok), .ack(ref_ack),
    .req(ref_req), .init_done(init_done)
  );

  sdinit_cmd_seq #(.BASE(MODE_BASE), .MODE_BITS(MODE_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .ref_req(ref_req),
    .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
    .trp_gap(ctl_trp_gap), .cpu_ready(cpu_ready), .ref_ack(ref_ack),
    .cmd(cmd), .addr(sd_addr), .err(mode_err)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

  // R1
  cmd_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd inside {CMD_NOP, CMD_PALL, CMD_MRS, CMD_REF});
endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;
  localparam int P  = 20;
  localparam int ND = 8;
  localparam int SI = 6;
  localparam int NI = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [1:0]  cpu_size = 2'b01;
  logic        ctl_trp_gap = 1'b0;
  logic        cpu_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, init_done, mode_err;
  logic [11:0] sd_addr;

  sdram_init_seq #(.PWR_CYCLES(P), .N_DUMMY(ND), .SHORT_IVL(SI), .NORMAL_IVL(NI)) i_sdram_init_seq (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_addr(cpu_addr), .cpu_size(cpu_size), .ctl_trp_gap(ctl_trp_gap),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .init_done(init_done), .mode_err(mode_err)
  );

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  // reference model state: phase 0 idle, 1 precharge, 2 gap, 3 mode load, 4 refresh
  int m_pwr = 0, m_tick = 0, m_dummy = 0, m_phase = 0;
  bit m_pend = 0, m_err = 0;
  logic [11:0] m_mode = '0;

  task automatic check(input string tag, input string what, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_pwr = 0; m_tick = 0; m_dummy = 0; m_phase = 0; m_pend = 0; m_err = 0; m_mode = '0;
    end else begin
      bit pok, rdy, ack, acc, good;
      int ivl, ph;
      pok  = (m_pwr == P);
      rdy  = (m_phase == 0) && pok && !m_pend;
      ack  = (m_phase == 0) && m_pend;
      acc  = cpu_valid && rdy;
      good = (cpu_addr[31:12] == 20'hFFFF8) && (cpu_size == 2'b01);
      ph   = m_phase;
      if (ack) begin
        m_pend = 0;
        if (m_dummy < ND) m_dummy++;
      end else if (pok && !m_pend) begin
        ivl = (m_dummy < ND) ? SI : NI;
        if (m_tick == ivl - 1) begin m_pend = 1; m_tick = 0; end
        else m_tick++;
      end
      case (m_phase)
        0: if (ack) ph = 4;
           else if (acc && good) begin ph = 1; m_mode = cpu_addr[11:0]; end
           else if (acc) m_err = 1;
        1: ph = ctl_trp_gap ? 2 : 3;
        2: ph = 3;
        default: ph = 0;
      endcase
      m_phase = ph;
      if (m_pwr < P) m_pwr++;
    end
  end

  // per-cycle comparison and port monitors
  int pall_cnt = 0, mrs_cnt = 0, ref_cnt = 0, last_pall = 0;
  int ref_times[$];
  bit seen_done = 0;
  logic [11:0] exp_mode = '0;

  always @(negedge clk) begin
    logic [3:0] cmd, ecmd;
    logic [11:0] eaddr;
    cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    case (m_phase)
      1: begin ecmd = 4'b0010; eaddr = 12'h400; end
      3: begin ecmd = 4'b0000; eaddr = m_mode; end
      4: begin ecmd = 4'b0001; eaddr = '0; end
      default: begin ecmd = 4'b0111; eaddr = '0; end
    endcase
    check("R3/R4/R7", "cmd", cmd, ecmd);
    check("R5", "sd_addr", sd_addr, eaddr);
    check("R2/R9/R10", "cpu_ready", cpu_ready, (m_phase == 0) && (m_pwr == P) && !m_pend);
    check("R8", "init_done", init_done, m_dummy == ND);
    check("R6", "mode_err", mode_err, m_err);
    if (rst_n) begin
      if (cmd == 4'b0010) begin pall_cnt++; last_pall = cyc; end
      if (cmd == 4'b0000) begin
        mrs_cnt++;
        if (ctl_trp_gap) check("R4", "precharge-to-load gap", cyc - last_pall, 2);
        else check("R3", "precharge-to-load gap", cyc - last_pall, 1);
        check("R5", "mode value on bus", sd_addr, exp_mode);
      end
      if (cmd == 4'b0001) begin ref_cnt++; ref_times.push_back(cyc); end
      if (init_done && !seen_done) begin
        seen_done = 1;
        check("R8", "refreshes when done rises", ref_cnt, ND);
      end
    end
  end

  task automatic do_write(input logic [31:0] a, input logic [1:0] s, input logic trp);
    @(negedge clk);
    ctl_trp_gap = trp; cpu_addr = a; cpu_size = s; cpu_valid = 1'b1;
    if (s == 2'b01 && a[31:12] == 20'hFFFF8) exp_mode = a[11:0];
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "reset cmd", {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    check("R1", "reset ready", cpu_ready, 0);
    rst_n = 1'b1;
    // R2: write held before the wait expires
    @(negedge clk);
    ctl_trp_gap = 1'b0; cpu_addr = 32'hFFFF8446; cpu_size = 2'b01; cpu_valid = 1'b1;
    exp_mode = 12'h446;
    repeat (P - 3) @(negedge clk);
    check("R2", "ready during wait", cpu_ready, 0);
    while (!cpu_ready) @(negedge clk);
    @(negedge clk);
    cpu_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R2", "held write issued", pall_cnt, 1);
    do_write(32'hFFFF88C8, 2'b01, 1'b1);       // R4 with gap
    do_write(32'hFFFF8848, 2'b10, 1'b0);       // R6 wrong size
    check("R6", "err after bad size", mode_err, 1);
    do_write(32'h12345426, 2'b01, 1'b0);       // R6 outside window
    check("R6", "no command for rejected writes", pall_cnt, 2);
    do_write(32'hFFFF8466, 2'b01, 1'b0);
    while (!seen_done) @(negedge clk);
    do_write(32'hFFFF8426, 2'b01, 1'b1);
    repeat (4 * NI) @(negedge clk);
    check("R3", "mode loads issued", mrs_cnt, 4);
    begin
      int mn = 1000;
      for (int i = 1; i < ND; i++)
        if (ref_times[i] - ref_times[i-1] < mn) mn = ref_times[i] - ref_times[i-1];
      check("R7", "dummy refresh spacing", mn, SI + 1);
    end
    check("R8", "normal refresh spacing",
          ref_times[ref_times.size()-1] - ref_times[ref_times.size()-2], NI + 1);
    check("R8", "done held", init_done, 1);
    finished = 1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end
endmodule